// File: doc/BRIEF.md
# Receiver-Detect Termination Controller

This block decides, for each of two independent receive channels, whether the input termination is left at high impedance or switched to 50 Ω. In the two probing modes it issues a one-cycle probe request to an analog far-end detect circuit at a fixed interval. It waits for a detect result and latches a successful detection, after which the termination is 50 Ω. In the capped probing mode it gives up after a fixed number of attempts. The two static modes hold the termination open or fixed at 50 Ω and never probe.

Each channel's two-bit mode comes from one of two places. When override is clear, both channels take a shared, already decoded four-level pin value. When override is set, each channel takes its own register field. A power-down input forces high impedance and turns the output drivers off while it is high. A power-down pulse that lasts long enough also re-arms the detect logic, so probing restarts from attempt zero. The probe interval, the attempt cap and the minimum re-arm width are parameters counted in clock cycles.

Top module: `rx_term_ctrl`

## Requirements
- R1: Mode 2'b00 keeps `term_50` low and issues no probe request.
- R2: Mode 2'b11 holds `term_50` high whenever `pwdn` is low and issues no probe request.
- R3: In mode 2'b01 or 2'b10, `probe_req` is a one-cycle pulse. The first pulse comes PROBE_INTERVAL cycles after probing starts, and later pulses follow every PROBE_INTERVAL cycles.
- R4: In mode 2'b01 without a detection, exactly MAX_PROBES requests are issued, then probing stops and `term_50` stays low.
- R5: In mode 2'b10, probing continues past MAX_PROBES requests until a detection occurs.
- R6: A cycle with both `detect_valid` and `detect_hit` high in a probing mode latches a detection. From the next cycle `term_50` is high and probing stops. A `detect_valid` with `detect_hit` low changes nothing.
- R7: With `mode_override` = 0, both channels use `pin_mode`. With `mode_override` = 1, channel i uses `reg_mode[2i+1:2i]` (channel A is bits 1:0, channel B is bits 3:2).
- R8: While `pwdn` is high, `term_50`, `probe_req` and `drv_en` are all low on both channels.
- R9: A `pwdn` pulse high for at least PD_MIN_CYCLES clock edges clears the latched detection and the attempt count on release. A shorter pulse keeps them.
- R10: A change of a channel's mode clears its attempt count and its latched detection, and restarts its probe interval.
- R11: The two channels run independently, each in its own mode, with their own counts and latches.
- R12: After reset, no probe is requested, `term_50` is low in the probing and open modes, and `drv_en` is high while `pwdn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_mode | input | 2 | Decoded four-level pin mode, shared by both channels |
| mode_override | input | 1 | 1 selects the per-channel register modes |
| reg_mode | input | 4 | Register modes; bits 1:0 channel A, bits 3:2 channel B |
| pwdn | input | 1 | Power-down; high forces high impedance and drivers off |
| detect_valid | input | 2 | Per-channel strobe: the detect result is valid this cycle |
| detect_hit | input | 2 | Per-channel detect result, 1 = far-end receiver present |
| probe_req | output | 2 | Per-channel one-cycle probe request |
| term_50 | output | 2 | Per-channel termination, 1 = 50 Ω, 0 = high impedance |
| drv_en | output | 2 | Per-channel output driver enable |

## Verification
The embedded assertions check, on every cycle, that the open mode never terminates or probes and that the fixed mode always terminates outside power-down. They also check that power-down silences probes, termination and drivers, and that probe pulses are single cycles. Further assertions confirm that the attempt count never passes its cap, that a latch survives until a mode change or re-arm, and that a mode change leaves cleared state behind. Only the bench scenarios show the timing of the first probe and the probe spacing, and the exact number of attempts before the capped mode gives up. The same holds for the pulse-width boundary that separates a re-arm from a brief power-down, and for the independence of the two channels under mixed modes.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  typedef enum logic [1:0] {
    TERM_OPEN     = 2'b00,
    PROBE_CAPPED  = 2'b01,
    PROBE_ENDLESS = 2'b10,
    TERM_FIXED    = 2'b11
  } term_mode_e;

  // Modes in which the far-end receiver is probed.
  function automatic logic mode_probes(input term_mode_e m);
    return (m == PROBE_CAPPED) || (m == PROBE_ENDLESS);
  endfunction

  // Termination decision for one channel.
  function automatic logic term_decision(input term_mode_e m, input logic det,
                                         input logic pd);
    if (pd) return 1'b0;
    return (m == TERM_FIXED) || (mode_probes(m) && det);
  endfunction

endpackage

// File: rtl/rxd_mode_sel.sv
module rxd_mode_sel #(
  parameter int NUM_CH = 2
) (
  input  logic [1:0]          pin_mode,
  input  logic                mode_override,
  input  logic [2*NUM_CH-1:0] reg_mode,
  output logic [2*NUM_CH-1:0] eff_mode
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sel
    assign eff_mode[2*ch +: 2] = mode_override ? reg_mode[2*ch +: 2] : pin_mode;
  end

endmodule

// File: rtl/rxd_pd_filter.sv
module rxd_pd_filter #(
  parameter int PD_MIN_CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwdn,
  output logic pd_rearm
);

  localparam int CW = $clog2(PD_MIN_CYCLES + 1);

  logic [CW-1:0] width_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      width_q <= '0;
    else if (!pwdn)
      width_q <= '0;
    else if (width_q != CW'(PD_MIN_CYCLES))
      width_q <= width_q + CW'(1);
  end

  // High from the cycle after the pulse has lasted long enough until release.
  assign pd_rearm = (width_q == CW'(PD_MIN_CYCLES));

  assert_rearm_after_pd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pd_rearm |-> $past(pwdn));

endmodule

// File: rtl/rxd_chan_fsm.sv
module rxd_chan_fsm
  import rxd_pkg::*;
#(
  parameter int PROBE_INTERVAL = 600000,
  parameter int MAX_PROBES     = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       pwdn,
  input  logic       pd_rearm,
  input  logic       det_valid,
  input  logic       det_hit,
  output logic       probe_req,
  output logic       term_50,
  output logic       drv_en
);

  localparam int TW = (PROBE_INTERVAL > 2) ? $clog2(PROBE_INTERVAL) : 1;
  localparam int AW = $clog2(MAX_PROBES + 1);

  term_mode_e    mode;
  logic [1:0]    mode_q;
  logic [TW-1:0] tick_q;
  logic [AW-1:0] tries_q;
  logic          det_q;

  logic mode_chg, budget_left, running, tick_wrap, det_event, clear_all;

  assign mode        = term_mode_e'(mode_i);
  assign mode_chg    = (mode_i != mode_q);
  assign clear_all   = mode_chg || pd_rearm;
  assign budget_left = (mode == PROBE_ENDLESS) || (tries_q < AW'(MAX_PROBES));
  assign running     = mode_probes(mode) && !pwdn && !det_q && !clear_all && budget_left;
  assign tick_wrap   = (tick_q == TW'(PROBE_INTERVAL - 1));
  assign det_event   = det_valid && det_hit && mode_probes(mode) && !pwdn && !clear_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 2'b00;
      tick_q  <= '0;
      tries_q <= '0;
      det_q   <= 1'b0;
    end else begin
      mode_q <= mode_i;
      if (clear_all) begin
        tick_q  <= '0;
        tries_q <= '0;
        det_q   <= 1'b0;
      end else begin
        if (det_event) det_q <= 1'b1;
        if (!running) begin
          tick_q <= '0;
        end else if (tick_wrap) begin
          tick_q <= '0;
          if (mode == PROBE_CAPPED) tries_q <= tries_q + AW'(1);
        end else begin
          tick_q <= tick_q + TW'(1);
        end
      end
    end
  end

  assign probe_req = running && tick_wrap;
  assign term_50   = term_decision(mode, det_q, pwdn);
  assign drv_en    = !pwdn;

  assert_open_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TERM_OPEN) |-> (!term_50 && !probe_req));
  assert_fixed_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TERM_FIXED && !pwdn) |-> (term_50 && !probe_req));
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    probe_req |=> !probe_req);
  assert_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q <= AW'(MAX_PROBES));
  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (det_q && !clear_all) |=> det_q);
  assert_pd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwdn |-> (!term_50 && !probe_req));
  assert_mode_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (tries_q == '0 && !det_q));

endmodule

// File: rtl/rx_term_ctrl.sv
module rx_term_ctrl #(
  parameter int NUM_CH         = 2,
  parameter int PROBE_INTERVAL = 600000,
  parameter int MAX_PROBES     = 50,
  parameter int PD_MIN_CYCLES  = 250
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          pin_mode,
  input  logic                mode_override,
  input  logic [2*NUM_CH-1:0] reg_mode,
  input  logic                pwdn,
  input  logic [NUM_CH-1:0]   detect_valid,
  input  logic [NUM_CH-1:0]   detect_hit,
  output logic [NUM_CH-1:0]   probe_req,
  output logic [NUM_CH-1:0]   term_50,
  output logic [NUM_CH-1:0]   drv_en
);

  logic [2*NUM_CH-1:0] eff_mode;
  logic                pd_rearm;

  rxd_mode_sel #(.NUM_CH(NUM_CH)) u_sel (
    .pin_mode      (pin_mode),
    .mode_override (mode_override),
    .reg_mode      (reg_mode),
    .eff_mode      (eff_mode)
  );

  rxd_pd_filter #(.PD_MIN_CYCLES(PD_MIN_CYCLES)) u_pd (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwdn     (pwdn),
    .pd_rearm (pd_rearm)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    rxd_chan_fsm #(
      .PROBE_INTERVAL (PROBE_INTERVAL),
      .MAX_PROBES     (MAX_PROBES)
    ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (eff_mode[2*ch +: 2]),
      .pwdn      (pwdn),
      .pd_rearm  (pd_rearm),
      .det_valid (detect_valid[ch]),
      .det_hit   (detect_hit[ch]),
      .probe_req (probe_req[ch]),
      .term_50   (term_50[ch]),
      .drv_en    (drv_en[ch])
    );
  end

  assert_pd_drivers_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwdn |-> (drv_en == '0));
  assert_pd_no_term_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwdn |-> (term_50 == '0));

endmodule

// File: tb/test_rx_term_ctrl.sv
module test_rx_term_ctrl;

  localparam int IVL = 10;
  localparam int CAP = 4;
  localparam int PDM = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pin_mode = 2'b00;
  logic       mode_override = 1'b0;
  logic [3:0] reg_mode = 4'b0000;
  logic       pwdn = 1'b0;
  logic [1:0] detect_valid = 2'b00;
  logic [1:0] detect_hit = 2'b00;
  logic [1:0] probe_req, term_50, drv_en;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  rx_term_ctrl #(
    .NUM_CH(2), .PROBE_INTERVAL(IVL), .MAX_PROBES(CAP), .PD_MIN_CYCLES(PDM)
  ) i_rx_term_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_mode(pin_mode), .mode_override(mode_override),
    .reg_mode(reg_mode), .pwdn(pwdn), .detect_valid(detect_valid),
    .detect_hit(detect_hit), .probe_req(probe_req), .term_50(term_50), .drv_en(drv_en)
  );

  // {override, pin[1:0], regA[1:0], regB[1:0], expected term_50 {B,A}}
  localparam logic [8:0] VEC [0:7] = '{
    9'b0_11_00_00_11,
    9'b0_00_11_11_00,
    9'b0_10_11_11_00,
    9'b0_01_11_11_00,
    9'b1_11_11_00_01,
    9'b1_11_00_11_10,
    9'b1_00_11_11_11,
    9'b1_11_10_01_00
  };

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_probes(input int n, output int ca, output int cb,
                              output int first_a, output int last_a);
    ca = 0; cb = 0; first_a = 0; last_a = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (probe_req[0]) begin
        ca++;
        if (first_a == 0) first_a = k;
        last_a = k;
      end
      if (probe_req[1]) cb++;
    end
  endtask

  task automatic pulse_hit(input int ch, input logic hit);
    detect_valid[ch] = 1'b1;
    detect_hit[ch]   = hit;
    @(negedge clk);
    detect_valid[ch] = 1'b0;
    detect_hit[ch]   = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int ca, cb, fa, la;
    // R12 reset state, probing mode selected by pin
    pin_mode = 2'b10;
    cycles(3);
    chk("R12 probe_req in reset", probe_req, 0);
    chk("R12 term_50 in reset", term_50, 0);
    chk("R12 drv_en in reset", drv_en, 3);
    rst_n = 1'b1;
    cycles(2);
    chk("R12 term_50 after reset", term_50, 0);

    // R7 mode source table
    foreach (VEC[i]) begin
      mode_override = VEC[i][8];
      pin_mode      = VEC[i][7:6];
      reg_mode      = {VEC[i][3:2], VEC[i][5:4]};
      cycles(2);
      chk($sformatf("R7 vector %0d term_50", i), term_50, VEC[i][1:0]);
    end

    // R3 R4 capped probing on A, B open (R11)
    mode_override = 1'b1;
    reg_mode = 4'b00_01;
    count_probes(60, ca, cb, fa, la);
    chk("R3 first probe cycle", fa, IVL);
    chk("R3 last probe spacing", la, CAP * IVL);
    chk("R4 probe count capped", ca, CAP);
    chk("R1 open channel B no probes", cb, 0);
    chk("R4 term stays open", term_50, 0);

    // R10 mode change restarts the attempt budget
    reg_mode = 4'b00_00;
    cycles(2);
    reg_mode = 4'b00_01;
    count_probes(60, ca, cb, fa, la);
    chk("R10 budget restarted", ca, CAP);

    // R5 endless probing
    reg_mode = 4'b00_10;
    count_probes(85, ca, cb, fa, la);
    chk("R5 endless probe count", ca, 8);

    // R6 detection latch
    reg_mode = 4'b00_11;
    cycles(1);
    reg_mode = 4'b00_10;
    count_probes(IVL, ca, cb, fa, la);
    chk("R3 probe seen before result", ca, 1);
    pulse_hit(0, 1'b0);
    chk("R6 miss ignored", term_50[0], 0);
    count_probes(IVL, ca, cb, fa, la);
    chk("R6 probing continues after miss", ca, 1);
    pulse_hit(0, 1'b1);
    chk("R6 hit latched", term_50[0], 1);
    count_probes(40, ca, cb, fa, la);
    chk("R6 probing stops after hit", ca, 0);
    chk("R6 termination held", term_50, 1);

    // R8 R9 short power-down keeps latch
    pwdn = 1'b1;
    @(negedge clk);
    chk("R8 term off in power-down", term_50, 0);
    chk("R8 drivers off in power-down", drv_en, 0);
    cycles(PDM - 2);
    pwdn = 1'b0;
    cycles(1);
    chk("R9 short pulse keeps detection", term_50[0], 1);
    chk("R8 drivers back on", drv_en, 3);

    // R9 long power-down re-arms
    pwdn = 1'b1;
    cycles(PDM);
    pwdn = 1'b0;
    count_probes(IVL, ca, cb, fa, la);
    chk("R9 long pulse clears detection", term_50[0], 0);
    chk("R9 probing restarts from zero", fa, IVL);

    // R10 mode change clears a latched detection
    pulse_hit(0, 1'b1);
    chk("R6 second hit latched", term_50[0], 1);
    reg_mode = 4'b00_01;
    cycles(1);
    chk("R10 mode change clears detection", term_50[0], 0);

    // R2 fixed mode and power-down
    reg_mode = 4'b11_11;
    count_probes(30, ca, cb, fa, la);
    chk("R2 fixed mode terminates", term_50, 3);
    chk("R2 fixed mode no probes", ca + cb, 0);
    pwdn = 1'b1;
    count_probes(5, ca, cb, fa, la);
    chk("R8 fixed mode off in power-down", term_50, 0);
    chk("R8 no probes in power-down", ca + cb, 0);
    pwdn = 1'b0;
    cycles(1);

    // R11 independent channels
    reg_mode = 4'b10_01;
    count_probes(60, ca, cb, fa, la);
    chk("R11 channel A capped", ca, CAP);
    chk("R11 channel B endless", cb, 6);
    pulse_hit(1, 1'b1);
    chk("R11 only channel B terminated", term_50, 2);

    summary();
  end

endmodule